// File: doc/BRIEF.md
# Misaligned Transfer Byte-Enable Splitter

This block sits between a CPU load/store unit and a 32-bit data bus. It takes one request (a byte address, an operand size of one, two or four bytes, write data and a direction) and emits the bus cycles the access needs. Each cycle carries a dword address (the byte address shifted right by two), an active-low four-bit lane enable and lane-aligned write data. An access that stays inside one dword costs one cycle. An access that runs past the end of a dword becomes two back-to-back cycles: the second one goes to the next dword and picks up the remaining bytes from lane 0 upward.

Both edges of the block use valid/ready. A request is taken in any cycle in which `req_valid` and `req_ready` are both high. `req_ready` is low while a sequence is in progress, so a request offered during that time is ignored. On the bus side, a cycle is presented with `cyc_valid`. The bus completes it by raising `cyc_ready`. Until that happens, every cycle field stays frozen, so the bus can apply back-pressure for as long as it needs. For loads, the block collects the lanes from one or both cycles and rotates them back into operand order. `done` pulses once for every request, whatever its direction.

Top module: `bus_split_unit`

## Requirements
- R1: After reset, `cyc_valid`, `busy` and `done` are low and `req_ready` is high.
- R2: When `req_valid` and `req_ready` are both high at a clock edge, the request is taken and its first cycle appears on the next cycle with `cyc_addr` equal to `req_addr[31:2]`.
- R3: Lane k carries the byte at offset k within the dword, in bits 8k+7..8k. `cyc_be_n[k]` is driven low exactly when lane k is used, and every presented cycle uses at least one lane.
- R4: Size encoding on `req_size`: 0 is a byte, 1 is a word, 2 is a dword, and 3 is treated as a dword.
- R5: A byte at any offset, a word at offset 0, 1 or 2, and a dword at offset 0 each take exactly one cycle.
- R6: A word at offset 3 and a dword at offset 1, 2 or 3 take two cycles. The first cycle enables the lanes from the offset through lane 3. The second cycle goes to dword address plus one, wrapping modulo 2^30, and enables the remaining lanes starting at lane 0.
- R7: For writes, operand byte i travels on the lane of byte address addr+i, in whichever cycle covers that address. Lanes that are not enabled carry zero.
- R8: While `cyc_valid` is high and `cyc_ready` is low, `cyc_valid`, `cyc_addr`, `cyc_be_n`, `cyc_wdata` and `cyc_write` hold their values.
- R9: `done` is a one-cycle pulse in the cycle after the handshake of the request's last bus cycle.
- R10: `busy` is high from the accept edge until the last cycle's handshake. `req_ready` equals not `busy`. A request offered while `busy` is high is ignored and does not change the cycles in flight.
- R11: For reads, byte i of `rd_data` is the byte returned on lane (addr+i) mod 4 by the cycle that covers addr+i. Bytes above the operand size are zero. The value is valid when `done` is high and stays unchanged until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Operand size code (R4) |
| req_wdata | input | 32 | Store data, operand byte 0 in bits 7..0 |
| busy | output | 1 | A sequence is in progress |
| cyc_valid | output | 1 | A bus cycle is presented |
| cyc_ready | input | 1 | Bus cycle completes at this edge |
| cyc_write | output | 1 | Direction of the presented cycle |
| cyc_addr | output | 30 | Dword address of the presented cycle |
| cyc_be_n | output | 4 | Active-low lane enables |
| cyc_wdata | output | 32 | Lane-aligned store data |
| cyc_rdata | input | 32 | Lane-aligned load data, sampled at the handshake |
| done | output | 1 | Request finished (pulse) |
| rd_data | output | 32 | Load result in operand order |

## Verification
The situation hardest to reach from the ports is a second request arriving while a split sequence is stalled on its first cycle. That request must be refused, and both cycles of the original access must still go out unchanged. The stimulus creates this by starting a misaligned word write and holding `cyc_ready` low on the first cycle. During the stall it offers a different request and checks that the frozen cycle and the later second cycle match the first access. The read model returns a value derived from each byte address, so every rotation and every two-cycle merge can be predicted independently for all twelve offset/size combinations. The set also includes a dword that wraps past the top of the address space.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} seq_state_t;

  typedef struct packed {
    logic [LANES-1:0]  en;
    logic [DATA_W-1:0] data;
  } lane_set_t;

  // lanes occupied by an operand of the given size code, starting at lane 0
  function automatic logic [LANES-1:0] size_mask(input logic [1:0] sz);
    logic [LANES-1:0] m;
    case (sz)
      2'd0:    m = LANES'(1);
      2'd1:    m = LANES'(3);
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/bsu_steer.sv
module bsu_steer
  import bsu_pkg::*;
(
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        sz,
  input  logic [DATA_W-1:0] wdata,
  output lane_set_t         first,
  output lane_set_t         second,
  output logic              split
);
  localparam int WIDE_L = 2 * LANES;
  localparam int WIDE_D = 2 * DATA_W;

  logic [LANES-1:0]  op_mask;
  logic [DATA_W-1:0] op_data;
  logic [WIDE_L-1:0] wide_en;
  logic [WIDE_D-1:0] wide_d;

  assign op_mask = size_mask(sz);

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign op_data[i*LANE_W +: LANE_W] = op_mask[i] ? wdata[i*LANE_W +: LANE_W] : '0;
  end

  assign wide_en = {{LANES{1'b0}}, op_mask} << off;
  assign wide_d  = {{DATA_W{1'b0}}, op_data} << (off * LANE_W);

  assign first.en   = wide_en[LANES-1:0];
  assign first.data = wide_d[DATA_W-1:0];
  assign second.en   = wide_en[WIDE_L-1:LANES];
  assign second.data = wide_d[WIDE_D-1:DATA_W];
  assign split = |wide_en[WIDE_L-1:LANES];
endmodule

// File: rtl/bsu_seq.sv
module bsu_seq
  import bsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       split_in,
  input  logic       cyc_ready,
  output seq_state_t state,
  output logic       lo_hs,
  output logic       last_hs,
  output logic       in_second
);
  seq_state_t state_q;
  logic       split_q;
  logic       hs;

  assign state     = state_q;
  assign hs        = (state_q != ST_IDLE) && cyc_ready;
  assign in_second = (state_q == ST_SECOND);
  assign lo_hs     = hs && (state_q == ST_FIRST);
  assign last_hs   = hs && (in_second || !split_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      split_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_FIRST;
          split_q <= split_in;
        end
        ST_FIRST: if (cyc_ready) state_q <= split_q ? ST_SECOND : ST_IDLE;
        ST_SECOND: if (cyc_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsu_gather.sv
module bsu_gather
  import bsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_hs,
  input  logic              last_hs,
  input  logic              in_second,
  input  logic              is_read,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        sz,
  input  logic [DATA_W-1:0] cyc_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  logic [DATA_W-1:0]   lo_q;
  logic [2*DATA_W-1:0] merged;
  logic [2*DATA_W-1:0] rotated;
  logic [LANES-1:0]    keep;
  logic [DATA_W-1:0]   result;

  assign merged  = in_second ? {cyc_rdata, lo_q} : {{DATA_W{1'b0}}, cyc_rdata};
  assign rotated = merged >> (off * LANE_W);
  assign keep    = size_mask(sz);

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign result[i*LANE_W +: LANE_W] = keep[i] ? rotated[i*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_hs;
      if (lo_hs) lo_q <= cyc_rdata;
      if (last_hs && is_read) rd_data <= result;
    end
  end
endmodule

// File: rtl/bus_split_unit.sv
module bus_split_unit
  import bsu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_size,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    busy,
  output logic                    cyc_valid,
  input  logic                    cyc_ready,
  output logic                    cyc_write,
  output logic [ADDR_W-OFF_W-1:0] cyc_addr,
  output logic [LANES-1:0]        cyc_be_n,
  output logic [DATA_W-1:0]       cyc_wdata,
  input  logic [DATA_W-1:0]       cyc_rdata,
  output logic                    done,
  output logic [DATA_W-1:0]       rd_data
);
  localparam int DW_W = ADDR_W - OFF_W;

  seq_state_t        state;
  logic              accept, lo_hs, last_hs, in_second, split;
  lane_set_t         set1, set2, set1_q, set2_q;
  logic [DW_W-1:0]   dw_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        sz_q;
  logic              write_q;

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  bsu_steer u_steer (
    .off    (req_addr[OFF_W-1:0]),
    .sz     (req_size),
    .wdata  (req_wdata),
    .first  (set1),
    .second (set2),
    .split  (split)
  );

  bsu_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .split_in  (split),
    .cyc_ready (cyc_ready),
    .state     (state),
    .lo_hs     (lo_hs),
    .last_hs   (last_hs),
    .in_second (in_second)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set1_q  <= '0;
      set2_q  <= '0;
      dw_q    <= '0;
      off_q   <= '0;
      sz_q    <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      set1_q  <= set1;
      set2_q  <= set2;
      dw_q    <= req_addr[ADDR_W-1:OFF_W];
      off_q   <= req_addr[OFF_W-1:0];
      sz_q    <= req_size;
      write_q <= req_write;
    end
  end

  assign cyc_valid = busy;
  assign cyc_write = write_q;
  assign cyc_addr  = in_second ? dw_q + 1'b1 : dw_q;
  assign cyc_be_n  = in_second ? ~set2_q.en : ~set1_q.en;
  assign cyc_wdata = in_second ? set2_q.data : set1_q.data;

  bsu_gather u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_hs     (lo_hs),
    .last_hs   (last_hs),
    .in_second (in_second),
    .is_read   (!write_q),
    .off       (off_q),
    .sz        (sz_q),
    .cyc_rdata (cyc_rdata),
    .rd_data   (rd_data),
    .done      (done)
  );
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        busy,
  input logic        cyc_valid,
  input logic        cyc_ready,
  input logic [29:0] cyc_addr,
  input logic [3:0]  cyc_be_n,
  input logic [31:0] cyc_wdata,
  input logic        done
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> cyc_valid && busy);

  p_lane_used_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> cyc_be_n != 4'hF);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cyc_ready |=> cyc_valid && $stable(cyc_addr) && $stable(cyc_be_n) && $stable(cyc_wdata));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cyc_valid && cyc_ready));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cyc_valid);
endmodule

bind bus_split_unit bsu_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .cyc_valid (cyc_valid),
  .cyc_ready (cyc_ready),
  .cyc_addr  (cyc_addr),
  .cyc_be_n  (cyc_be_n),
  .cyc_wdata (cyc_wdata),
  .done      (done)
);

// File: tb/bus_split_unit_tb.sv
module bus_split_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // {size, addr, wdata}
  localparam logic [65:0] VEC [NVEC] = '{
    {2'd0, 32'h0000_1000, 32'h0000_00A1},
    {2'd0, 32'h0000_1001, 32'h0000_00B2},
    {2'd0, 32'h0000_1006, 32'h0000_00C3},
    {2'd0, 32'h0000_100B, 32'h0000_00D4},
    {2'd1, 32'h0000_2004, 32'h0000_1122},
    {2'd1, 32'h0000_2005, 32'h0000_3344},
    {2'd1, 32'h0000_2006, 32'h0000_5566},
    {2'd1, 32'h0000_2003, 32'h0000_7788},
    {2'd2, 32'h0000_3000, 32'hA1B2_C3D4},
    {2'd2, 32'h0000_3005, 32'h1234_5678},
    {2'd2, 32'h0000_3002, 32'h9ABC_DEF0},
    {2'd3, 32'h0000_300B, 32'h0F1E_2D3C},
    {2'd2, 32'hFFFF_FFFF, 32'hCAFE_F00D}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        busy;
  logic        cyc_valid;
  logic        cyc_ready = 1'b0;
  logic        cyc_write;
  logic [29:0] cyc_addr;
  logic [3:0]  cyc_be_n;
  logic [31:0] cyc_wdata;
  logic [31:0] cyc_rdata = '0;
  logic        done;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_split_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .busy(busy), .cyc_valid(cyc_valid),
    .cyc_ready(cyc_ready), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .cyc_be_n(cyc_be_n), .cyc_wdata(cyc_wdata), .cyc_rdata(cyc_rdata),
    .done(done), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: every byte address b returns b[7:0] ^ 8'hA5
  function automatic logic [31:0] mem_word(input logic [29:0] dw);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] b;
      b = {dw, 2'(k)};
      w[k*8 +: 8] = b[7:0] ^ 8'hA5;
    end
    return w;
  endfunction

  task automatic run_txn(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                         input logic [31:0] wd, input bit stall);
    logic [3:0]  en [2];
    logic [31:0] dat [2];
    logic [29:0] dwa [2];
    logic [31:0] exp_rd;
    int nb, ncyc;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    en[0] = '0; en[1] = '0; dat[0] = '0; dat[1] = '0;
    dwa[0] = addr[31:2]; dwa[1] = addr[31:2] + 30'd1;
    exp_rd = '0; ncyc = 1;
    for (int i = 0; i < nb; i++) begin
      logic [31:0] b;
      int c;
      b = addr + 32'(i);
      c = (b[31:2] != addr[31:2]) ? 1 : 0;
      if (c == 1) ncyc = 2;
      en[c][b[1:0]] = 1'b1;
      dat[c][b[1:0]*8 +: 8] = wd[i*8 +: 8];
      exp_rd[i*8 +: 8] = b[7:0] ^ 8'hA5;
    end

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    check(req_ready == 1'b1, "R10 ready when idle", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      check(cyc_valid == 1'b1, "R2 cycle presented", 32'(cyc_valid), 32'd1);
      check(cyc_addr == dwa[c], (c == 0) ? "R2 first address" : "R6 second address", 32'(cyc_addr), 32'(dwa[c]));
      check(cyc_be_n == ~en[c], (ncyc == 1) ? "R5 lane enables" : "R6 lane enables", 32'(cyc_be_n), 32'(~en[c]));
      check(cyc_write == wr, "R3 direction", 32'(cyc_write), 32'(wr));
      if (wr) check(cyc_wdata == dat[c], "R7 lane data", cyc_wdata, dat[c]);
      if (stall && c == 0) begin
        req_valid = 1'b1; req_write = ~wr; req_size = 2'd2; req_addr = 32'h0000_5551; req_wdata = 32'hDEAD_BEEF;
        check(busy == 1'b1, "R10 busy during sequence", 32'(busy), 32'd1);
        check(req_ready == 1'b0, "R10 refuse while busy", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        check(cyc_addr == dwa[0], "R8 address held", 32'(cyc_addr), 32'(dwa[0]));
        check(cyc_be_n == ~en[0], "R8 enables held", 32'(cyc_be_n), 32'(~en[0]));
        check(cyc_wdata == dat[0], "R8 data held", cyc_wdata, dat[0]);
      end
      cyc_ready = 1'b1;
      cyc_rdata = mem_word(cyc_addr);
      @(posedge clk);
      @(negedge clk);
      cyc_ready = 1'b0;
      cyc_rdata = '0;
    end
    check(done == 1'b1, "R9 done after last cycle", 32'(done), 32'd1);
    check(cyc_valid == 1'b0, (ncyc == 1) ? "R5 single cycle" : "R6 exactly two cycles", 32'(cyc_valid), 32'd0);
    check(busy == 1'b0, "R10 idle after last cycle", 32'(busy), 32'd0);
    if (!wr) check(rd_data == exp_rd, "R11 read reassembly", rd_data, exp_rd);
    @(negedge clk);
    check(done == 1'b0, "R9 done is one pulse", 32'(done), 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cyc_valid == 1'b0, "R1 reset cyc_valid", 32'(cyc_valid), 32'd0);
    check(busy == 1'b0, "R1 reset busy", 32'(busy), 32'd0);
    check(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
    check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;

    // table walk: writes then reads over every offset/size pair (R4 via size 3)
    for (int v = 0; v < NVEC; v++)
      run_txn(1'b1, VEC[v][65:64], VEC[v][63:32], VEC[v][31:0], 1'b0);
    for (int v = 0; v < NVEC; v++)
      run_txn(1'b0, VEC[v][65:64], VEC[v][63:32], VEC[v][31:0], 1'b0);

    // R10/R8: stalled split with an intruding request
    run_txn(1'b1, 2'd1, 32'h0000_4003, 32'h0000_6A5B, 1'b1);
    run_txn(1'b0, 2'd2, 32'h0000_4001, 32'h0, 1'b1);

    // R11: a write does not disturb the last read result
    held = rd_data;
    run_txn(1'b1, 2'd0, 32'h0000_0010, 32'h0000_0077, 1'b0);
    check(rd_data == held, "R11 result held over write", rd_data, held);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule